// File: doc/BRIEF.md
# UART Receive FIFO with Status and Control Registers

This block sits between a UART deserializer and a processor register bus. Received bytes and line-break events come in one per cycle. They are stored in a byte-wide receive FIFO. When the FIFO is switched off, they go into a single holding register instead. Software reads the oldest byte, the FIFO occupancy word and a sticky error word through a small 32-bit register port, and can flush either direction's FIFO with self-clearing control bits.

The transmit side is not part of this block. Its occupancy and full flag are passed straight through into the status word, and its flush request leaves as a one-cycle pulse. For an interrupt unit, the block exports two single-cycle event pulses: one for any incoming byte or break, and one for any error, overflow or underflow.

The register port decodes byte addresses. The control word sits at 0x0, the FIFO status word at 0x4, the error word at 0x8 and the receive buffer at 0xC. Every read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. A write has priority over a read issued in the same cycle.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: After reset, the control word, the status word (with the transmit inputs at zero) and the error word all read 0, and `data_ready` is low.
- R2: Control bit0 enables the FIFO. Bits 1 and 2 always read back as 0. All other written bits read back as written. Writing bit2 produces a one-cycle `tx_flush` pulse.
- R3: Writing control bit1 empties the receive FIFO: the count reads 0 and `data_ready` drops, with the enable bit unchanged.
- R4: With the FIFO enabled, bytes are returned in arrival order, and status bits[7:0] give the occupancy. `data_ready` stays high while bytes remain and goes low once the last byte is read.
- R5: When the FIFO holds DEPTH bytes, status bit8 is 1 and status bits[7:0] read 0.
- R6: A byte that arrives while the FIFO is full is dropped. It sets error bit0 (overrun) and pulses `err_pulse`, and `data_ready` stays high.
- R7: Reading the receive buffer with the FIFO enabled and empty returns 0 and pulses `err_pulse`. The count is left unchanged.
- R8: A break pushes a 0x00 byte, sets error bit3 and pulses `err_pulse`.
- R9: Error bit1 records a parity error and bit2 a framing error, both flagged with a received byte. Status bit9 is high while any error bit is set. Reading the error word returns it and clears it.
- R10: With the FIFO disabled, a byte lands in the holding register and raises `data_ready`. Reading the buffer returns the byte and clears `data_ready`. A second byte arriving before that read overwrites the first and sets overrun.
- R11: Status bits[23:16] show `tx_level` and bit24 shows `tx_full`.
- R12: `rx_pulse` is high for one cycle after each cycle with `rx_valid` or `rx_break`.
- R13: `bus_rvalid` is high in the cycle after every read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break detected on the line |
| rx_parity_err | input | 1 | Parity error for the byte in `rx_byte` |
| rx_frame_err | input | 1 | Framing error for the byte in `rx_byte` |
| tx_level | input | 8 | Transmit FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| data_ready | output | 1 | Receive data available |
| err_pulse | output | 1 | Error event pulse |
| rx_pulse | output | 1 | Receive event pulse |
| tx_flush | output | 1 | Transmit FIFO flush pulse |

## Verification
The bench builds the block with DEPTH=4 and ADDR_W=4. With that depth, the full condition, the hidden count and dropped bytes are reached after four pushes. A few hundred random operations then wrap the pointers many times, which exercises pointer equality in both the empty and the full state. The narrow address keeps every decoded register reachable, along with the bus behaviour around them.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_ERR  = 2'd2,
    REG_RBUF = 2'd3
  } rxf_reg_e;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_RXCLR = 1;
  localparam int CTRL_TXCLR = 2;

  localparam int STAT_RXFULL = 8;
  localparam int STAT_RXERR  = 9;
  localparam int STAT_TXLVL  = 16;
  localparam int STAT_TXFULL = 24;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rxf_err_t;
endpackage

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [W-1:0]     rd_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_ptr];
  end
endmodule

// File: rtl/rxf_ptrs.sv
module rxf_ptrs #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
  a_r4_push_grows: assert property (@(posedge clk) disable iff (rst)
    (!flush && push && !pop) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/rxf_errstat.sv
module rxf_errstat
  import uart_rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rxf_err_t set_i,
  input  logic     clr_i,
  output rxf_err_t err_q
);
  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (clr_i ? rxf_err_t'('0) : err_q) | set_i;
  end

  a_r9_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i == '0) |=> (err_q == '0));
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_break,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic [7:0]        tx_level,
  input  logic              tx_full,
  output logic              data_ready,
  output logic              err_pulse,
  output logic              rx_pulse,
  output logic              tx_flush
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Bus decode
  logic     addr_hit;
  rxf_reg_e sel;
  logic     wr_cyc, rd_cyc, ctrl_wr, rbuf_rd, err_rd;

  assign addr_hit = ((bus_addr >> 4) == '0) && (bus_addr[1:0] == 2'b00);
  assign sel      = rxf_reg_e'(bus_addr[3:2]);
  assign wr_cyc   = bus_wr && addr_hit;
  assign rd_cyc   = bus_rd && !bus_wr && addr_hit;
  assign ctrl_wr  = wr_cyc && (sel == REG_CTRL);
  assign rbuf_rd  = rd_cyc && (sel == REG_RBUF);
  assign err_rd   = rd_cyc && (sel == REG_ERR);

  // Control word
  logic [31:0] ctrl_q;
  logic        en;
  logic        flush;
  assign en    = ctrl_q[CTRL_EN];
  assign flush = ctrl_wr && bus_wdata[CTRL_RXCLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      tx_flush <= 1'b0;
    end else begin
      tx_flush <= ctrl_wr && bus_wdata[CTRL_TXCLR];
      if (ctrl_wr) begin
        ctrl_q <= bus_wdata & ~((32'd1 << CTRL_RXCLR) | (32'd1 << CTRL_TXCLR));
      end
    end
  end

  // Receive side
  logic             rx_in;
  logic [7:0]       rx_dat;
  logic             full, empty;
  logic             push, pop, underflow, drop_fifo, drop_hold;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [7:0]       mem_q;

  assign rx_in     = rx_valid || rx_break;
  assign rx_dat    = rx_break ? 8'h00 : rx_byte;
  assign pop       = rbuf_rd && en && !empty;
  assign underflow = rbuf_rd && en && empty;
  assign push      = rx_in && en && !full && !flush;
  assign drop_fifo = rx_in && en && full && !flush;

  rxf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  rxf_storage #(.DEPTH(DEPTH), .W(8)) u_mem (
    .clk    (clk),
    .wr_en  (push),
    .wr_ptr (wr_ptr),
    .wr_data(rx_dat),
    .rd_en  (pop),
    .rd_ptr (rd_ptr),
    .rd_q   (mem_q)
  );

  // Holding register for the FIFO-disabled mode
  logic       hold_vld_q;
  logic [7:0] hold_q;
  logic       hold_load;
  assign hold_load = rx_in && !en;
  assign drop_hold = hold_load && hold_vld_q && !rbuf_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else if (hold_load) begin
      hold_vld_q <= 1'b1;
      hold_q     <= rx_dat;
    end else if (rbuf_rd && !en) begin
      hold_vld_q <= 1'b0;
    end
  end

  // Error word
  rxf_err_t err_set, err_q;
  always_comb begin
    err_set     = '0;
    err_set.ovr = drop_fifo || drop_hold;
    err_set.par = rx_valid && rx_parity_err;
    err_set.frm = rx_valid && rx_frame_err;
    err_set.brk = rx_break;
  end

  rxf_errstat u_err (
    .clk  (clk),
    .rst  (rst),
    .set_i(err_set),
    .clr_i(err_rd),
    .err_q(err_q)
  );

  // Event pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      rx_pulse  <= 1'b0;
    end else begin
      err_pulse <= (err_set != '0) || underflow;
      rx_pulse  <= rx_in;
    end
  end

  assign data_ready = en ? !empty : hold_vld_q;

  // Status word
  logic [7:0]  cnt8;
  logic [31:0] stat_word;
  always_comb begin
    cnt8 = '0;
    cnt8[CNT_W-1:0] = count;
    stat_word = '0;
    stat_word[7:0] = full ? 8'h00 : cnt8;
    stat_word[STAT_RXFULL] = full;
    stat_word[STAT_RXERR]  = (err_q != '0);
    stat_word[STAT_TXLVL +: 8] = tx_level;
    stat_word[STAT_TXFULL] = tx_full;
  end

  // Read path: one registered stage, byte from memory selected afterwards
  logic [31:0] word_q;
  logic        src_mem_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      src_mem_q  <= 1'b0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd && !bus_wr;
      src_mem_q  <= pop;
      word_q     <= '0;
      if (rd_cyc) begin
        unique case (sel)
          REG_CTRL: word_q <= ctrl_q;
          REG_STAT: word_q <= stat_word;
          REG_ERR:  word_q <= {28'd0, err_q};
          REG_RBUF: word_q <= en ? 32'd0 : {24'd0, hold_q};
          default:  word_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = src_mem_q ? {24'd0, mem_q} : word_q;

  a_r13_read_valid: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> bus_rvalid);
  a_r12_rx_event: assert property (@(posedge clk) disable iff (rst)
    rx_in |=> rx_pulse);
  a_r7_underflow_err: assert property (@(posedge clk) disable iff (rst)
    (rbuf_rd && en && empty) |=> (err_pulse && bus_rdata == 32'd0));
  a_r10_hold_cleared: assert property (@(posedge clk) disable iff (rst)
    (rbuf_rd && !en && !rx_in) |=> !data_ready);
  a_r2_tx_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[CTRL_TXCLR]) |=> tx_flush);
  a_r6_drop_keeps_ready: assert property (@(posedge clk) disable iff (rst)
    (drop_fifo && !rbuf_rd) |=> (data_ready && err_pulse));
endmodule

// File: tb/test_uart_rx_fifo_status.sv
module test_uart_rx_fifo_status;
  localparam int DEPTH = 4;
  localparam int ADDR_W = 4;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_ERR  = 4'h8;
  localparam logic [ADDR_W-1:0] A_RBUF = 4'hC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic rx_valid = 0, rx_break = 0, rx_parity_err = 0, rx_frame_err = 0;
  logic [7:0] rx_byte = '0;
  logic [7:0] tx_level = '0;
  logic tx_full = 0;
  logic data_ready, err_pulse, rx_pulse, tx_flush;

  uart_rx_fifo_status #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_uart_rx_fifo_status (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .tx_level(tx_level), .tx_full(tx_full), .data_ready(data_ready),
    .err_pulse(err_pulse), .rx_pulse(rx_pulse), .tx_flush(tx_flush)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // Reference model
  logic [7:0]  mq[$];
  logic [31:0] m_ctrl = '0;
  logic [3:0]  m_err = '0;
  logic [7:0]  m_hold = '0;
  bit          m_hold_v = 0;

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    if (mq.size() == DEPTH) s[8] = 1'b1;
    else s[7:0] = 8'(mq.size());
    s[9] = (m_err != 0);
    s[23:16] = tx_level;
    s[24] = tx_full;
    return s;
  endfunction

  function automatic bit exp_ready();
    return m_ctrl[0] ? (mq.size() != 0) : m_hold_v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, output bit flush_seen);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    flush_seen = tx_flush;
    if (a == A_CTRL) begin
      m_ctrl = d & ~32'h6;
      if (d[1]) mq.delete();
    end
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d, output bit ep);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
    ep = err_pulse;
    chk("R13 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  // Reads a register and compares with the model, updating model side effects
  task automatic read_chk(input string req, input logic [ADDR_W-1:0] a);
    logic [31:0] d, e;
    bit ep, exp_ep;
    exp_ep = 0;
    case (a)
      A_CTRL: e = m_ctrl;
      A_STAT: e = exp_stat();
      A_ERR: begin e = 32'(m_err); m_err = '0; end
      default: begin
        if (m_ctrl[0]) begin
          if (mq.size() == 0) begin e = 0; exp_ep = 1; end
          else e = 32'(mq.pop_front());
        end else begin
          e = 32'(m_hold); m_hold_v = 0;
        end
      end
    endcase
    do_read(a, d, ep);
    chk(req, d, e);
    if (a == A_RBUF) begin
      chk({req, " err_pulse"}, 32'(ep), 32'(exp_ep));
      chk({req, " data_ready"}, 32'(data_ready), 32'(exp_ready()));
    end
  endtask

  task automatic push(input string req, input logic [7:0] b, input bit par, input bit frm, input bit brk);
    bit drop;
    logic [7:0] v;
    v = brk ? 8'h00 : b;
    drop = 0;
    if (m_ctrl[0]) begin
      if (mq.size() == DEPTH) drop = 1;
      else mq.push_back(v);
    end else begin
      if (m_hold_v) drop = 1;
      m_hold = v; m_hold_v = 1;
    end
    if (drop) m_err[0] = 1;
    if (par && !brk) m_err[1] = 1;
    if (frm && !brk) m_err[2] = 1;
    if (brk) m_err[3] = 1;
    @(negedge clk);
    rx_valid = !brk; rx_break = brk; rx_byte = b;
    rx_parity_err = par && !brk; rx_frame_err = frm && !brk;
    @(negedge clk);
    rx_valid = 0; rx_break = 0; rx_parity_err = 0; rx_frame_err = 0;
    chk({req, " R12 rx_pulse"}, 32'(rx_pulse), 32'd1);
    chk({req, " err_pulse"}, 32'(err_pulse), 32'(drop || par || frm || brk));
    chk({req, " data_ready"}, 32'(data_ready), 32'(exp_ready()));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    bit fl;
    logic [31:0] d;
    bit ep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 data_ready", 32'(data_ready), 32'd0);
    read_chk("R1 ctrl", A_CTRL);
    read_chk("R1 stat", A_STAT);
    read_chk("R1 err", A_ERR);

    // R10 holding register
    push("R10 hold", 8'hA5, 0, 0, 0);
    read_chk("R10 hold read", A_RBUF);
    push("R10 first", 8'h11, 0, 0, 0);
    push("R10 overwrite", 8'h22, 0, 0, 0);
    read_chk("R10 overrun err", A_ERR);
    read_chk("R9 cleared", A_ERR);
    read_chk("R10 newest byte", A_RBUF);

    // R2 control
    do_write(A_CTRL, 32'hF0F7, fl);
    chk("R2 tx_flush pulse", 32'(fl), 32'd1);
    @(negedge clk);
    chk("R2 tx_flush single", 32'(tx_flush), 32'd0);
    read_chk("R2 ctrl readback", A_CTRL);

    // R5/R6/R4 fill, overflow, drain
    for (int i = 0; i < DEPTH; i++) push("R4 fill", 8'(8'h30 + i), 0, 0, 0);
    read_chk("R5 full status", A_STAT);
    push("R6 overflow", 8'hEE, 0, 0, 0);
    read_chk("R9 status err bit", A_STAT);
    read_chk("R6 overrun bit", A_ERR);
    for (int i = 0; i < DEPTH; i++) begin
      read_chk("R4 order", A_RBUF);
      read_chk("R4 count", A_STAT);
    end

    // R7 underflow
    read_chk("R7 underflow", A_RBUF);
    read_chk("R7 count unchanged", A_STAT);

    // R8 break
    push("R8 break", 8'h77, 0, 0, 1);
    read_chk("R8 count", A_STAT);
    read_chk("R8 break bit", A_ERR);
    read_chk("R8 zero byte", A_RBUF);

    // R9 parity / framing
    push("R9 parity", 8'h01, 1, 0, 0);
    read_chk("R9 parity bit", A_ERR);
    push("R9 frame", 8'h02, 0, 1, 0);
    read_chk("R9 frame bit", A_ERR);

    // R3 receive flush
    push("R3 pre", 8'h44, 0, 0, 0);
    do_write(A_CTRL, 32'h3, fl);
    chk("R3 no tx flush", 32'(fl), 32'd0);
    chk("R3 data_ready", 32'(data_ready), 32'(exp_ready()));
    read_chk("R3 count", A_STAT);
    read_chk("R3 ctrl", A_CTRL);

    // R11 transmit fields
    tx_level = 8'h35; tx_full = 1;
    read_chk("R11 tx fields", A_STAT);
    tx_level = 8'h00; tx_full = 0;

    // Random mix checked against the model
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) push("R4 rand push", 8'($urandom), 0, 0, ($urandom_range(0, 15) == 0));
      else if (op < 7) read_chk("R4 rand read", A_RBUF);
      else if (op < 9) read_chk("R5 rand stat", A_STAT);
      else read_chk("R9 rand err", A_ERR);
    end

    // Disabled mode again after FIFO use
    do_write(A_CTRL, 32'h0, fl);
    push("R10 late", 8'h5A, 0, 0, 0);
    read_chk("R10 late read", A_RBUF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule